// File: doc/BRIEF.md
# Alternating Dual Down-Counter with Output Combiner

The block contains two down-counters: a narrow one (timer A, 8 bits by default) and a wide one (timer B, 16 bits by default). Each can run once and stop, or reload and run continuously. In alternating mode, hardware passes a single run token between them. When the running timer reaches its terminal count, hardware stops it and starts the other one. This produces an endless A, B, A, B sequence of intervals, each with its own length. Counting advances only in cycles where the shared `tick` strobe is high.

Each timer has an output bit that toggles at its terminal count. One of four logic functions combines the two output bits. Any of three pins can be switched from its ordinary port data to a timer-derived signal: pin 0 takes the combined signal, pin 1 takes timer A's output and pin 2 takes timer B's output.

Software programs the block through a byte-wide write port:

| Address | Contents |
|---|---|
| 0 | Control: bit 0 run A, bit 1 run B, bit 2 continuous A, bit 3 continuous B, bit 4 alternating enable |
| 1 | Timeout flags, write 1 to clear: bit 0 A, bit 1 B |
| 2 | Routing: bits 1:0 combine function, bits 4:2 pin selects for pins 0..2 |
| 3 | Reload value for A |
| 4, 5 | Reload value for B, low byte then high byte |

Top module: `pp_timer_top`

## Requirements
- R1: After reset, both run enables, both timeout flags and both timer outputs are 0, and every pin shows its `port_d` bit.
- R2: Setting a run enable (control bit 0 for A, bit 1 for B) loads the reload value from address 3 (A) or addresses 4/5 (B). With `tick` held high, a single-pass timer (continuous bit clear) keeps its run enable high for reload+1 cycles after the write, then clears it. A reload of 0 behaves like a reload of 1.
- R3: A timer with its continuous bit set (control bit 2 for A, bit 3 for B) reloads at terminal count and keeps running. With `tick` high, its terminal counts are exactly reload cycles apart.
- R4: While `tick` is low, a running timer does not advance, does not reach terminal count and keeps its run enable.
- R5: A timer's timeout flag is set at every terminal count. Writing 1 to its bit at address 1 (bit 0 A, bit 1 B) clears it. A terminal count in the same cycle as the clear leaves the flag set.
- R6: With the alternating enable (control bit 4) set, a terminal count clears the finishing timer's run enable and sets the other timer's run enable. With `tick` high, A stays enabled for reloadA+1 cycles and B for reloadB+1 cycles, and the two are never enabled together.
- R7: A control write that sets both run enables while also setting the alternating enable starts only timer A. The B enable is ignored.
- R8: If the alternating enable is cleared while a timer runs, that timer completes its pass and no hand-off follows.
- R9: Each timer output toggles at that timer's terminal count and holds its level while the timer is stopped.
- R10: Routing bits 1:0 choose the combining function: 0 AND, 1 OR, 2 NOR, 3 NAND of the two timer outputs.
- R11: Routing bit 2+i chooses the source of pin i: 0 selects `port_d[i]`; 1 selects the combined signal for pin 0, timer A's output for pin 1 and timer B's output for pin 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Count enable strobe shared by both timers |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register address |
| cfg_wdata | input | 8 | Register write data |
| port_d | input | 3 | Ordinary port data for the three pins |
| pin_q | output | 3 | Pin values after routing |
| run_a | output | 1 | Run enable of timer A |
| run_b | output | 1 | Run enable of timer B |
| tmo_a | output | 1 | Timeout flag of timer A |
| tmo_b | output | 1 | Timeout flag of timer B |
| tout_a | output | 1 | Toggle output of timer A |
| tout_b | output | 1 | Toggle output of timer B |

## Verification
The hand-off and single-pass properties assume the two timers never reach terminal count in the same cycle, and that software does not write the control register in the cycle where a hand-off or stop is checked. The stimulus only enables alternation after both timers are stopped. It writes the control register only while a timer is mid-pass, never at a terminal count edge. The flag-clear collision test aims a write at address 1, not at the control register, onto the terminal count edge.

// File: rtl/pp_timer_pkg.sv
`timescale 1ns/1ps
package pp_timer_pkg;

  typedef enum logic [1:0] {
    CMB_AND  = 2'd0,
    CMB_OR   = 2'd1,
    CMB_NOR  = 2'd2,
    CMB_NAND = 2'd3
  } cmb_fn_e;

  localparam logic [2:0] ADR_CTRL   = 3'd0;
  localparam logic [2:0] ADR_FLAG   = 3'd1;
  localparam logic [2:0] ADR_ROUTE  = 3'd2;
  localparam logic [2:0] ADR_RLD_A  = 3'd3;
  localparam logic [2:0] ADR_RLD_B0 = 3'd4;

  localparam int CTL_RUN_A  = 0;
  localparam int CTL_RUN_B  = 1;
  localparam int CTL_CONT_A = 2;
  localparam int CTL_CONT_B = 3;
  localparam int CTL_PP     = 4;

  // Combines the two timer outputs under the selected function.
  function automatic logic combine(input cmb_fn_e f, input logic a, input logic b);
    case (f)
      CMB_AND:  return a & b;
      CMB_OR:   return a | b;
      CMB_NOR:  return ~(a | b);
      default:  return ~(a & b);
    endcase
  endfunction

endpackage

// File: rtl/pp_timer_cnt.sv
`timescale 1ns/1ps
module pp_timer_cnt #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic         tick,
  input  logic [W-1:0] reload,
  output logic         tc,
  output logic         tout
);

  logic [W-1:0] cnt;
  logic         run_d;
  logic         start;

  // Last counting step: a value of 1 or 0 ends the pass.
  function automatic logic at_last(input logic [W-1:0] c);
    return (c <= W'(1));
  endfunction

  function automatic logic [W-1:0] step(input logic [W-1:0] c, input logic [W-1:0] rl);
    return at_last(c) ? rl : c - W'(1);
  endfunction

  assign start = run & ~run_d;
  assign tc    = run & ~start & tick & at_last(cnt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      run_d <= 1'b0;
      tout  <= 1'b0;
    end else begin
      run_d <= run;
      if (start)
        cnt <= reload;
      else if (run && tick)
        cnt <= step(cnt, reload);
      if (tc)
        tout <= ~tout;
    end
  end

  // R2: a rising run enable loads the reload value
  p_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> cnt == $past(reload));

  // R4: no tick, no movement
  p_freeze_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !tick && !start) |=> $stable(cnt));

endmodule

// File: rtl/pp_timer_regs.sv
`timescale 1ns/1ps
module pp_timer_regs
  import pp_timer_pkg::*;
#(
  parameter int A_W   = 8,
  parameter int B_W   = 16,
  parameter int NPINS = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [2:0]       cfg_addr,
  input  logic [7:0]       cfg_wdata,
  input  logic             tc_a,
  input  logic             tc_b,
  output logic             run_a,
  output logic             run_b,
  output logic             tmo_a,
  output logic             tmo_b,
  output cmb_fn_e          cmb_fn,
  output logic [NPINS-1:0] pin_sel,
  output logic [A_W-1:0]   reload_a,
  output logic [B_W-1:0]   reload_b
);

  localparam int B_BYTES = (B_W + 7) / 8;

  logic cont_a, cont_b, pp_en;
  logic wr_ctrl, wr_flag, wr_route;
  logic run_a_n, run_b_n;
  logic [B_BYTES*8-1:0] reload_b_pad;

  assign wr_ctrl  = cfg_we && (cfg_addr == ADR_CTRL);
  assign wr_flag  = cfg_we && (cfg_addr == ADR_FLAG);
  assign wr_route = cfg_we && (cfg_addr == ADR_ROUTE);
  assign reload_b = reload_b_pad[B_W-1:0];

  // Run-token update: hardware stop/hand-off, then a software write replaces it.
  always_comb begin
    run_a_n = run_a;
    run_b_n = run_b;
    if (tc_a && (pp_en || !cont_a)) run_a_n = 1'b0;
    if (tc_b && (pp_en || !cont_b)) run_b_n = 1'b0;
    if (tc_a && pp_en) run_b_n = 1'b1;
    if (tc_b && pp_en) run_a_n = 1'b1;
    if (wr_ctrl) begin
      run_a_n = cfg_wdata[CTL_RUN_A];
      run_b_n = cfg_wdata[CTL_RUN_B] &&
                !(cfg_wdata[CTL_PP] && cfg_wdata[CTL_RUN_A]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_a    <= 1'b0;
      run_b    <= 1'b0;
      cont_a   <= 1'b0;
      cont_b   <= 1'b0;
      pp_en    <= 1'b0;
      tmo_a    <= 1'b0;
      tmo_b    <= 1'b0;
      cmb_fn   <= CMB_AND;
      pin_sel  <= '0;
      reload_a <= '0;
    end else begin
      run_a <= run_a_n;
      run_b <= run_b_n;
      if (wr_ctrl) begin
        cont_a <= cfg_wdata[CTL_CONT_A];
        cont_b <= cfg_wdata[CTL_CONT_B];
        pp_en  <= cfg_wdata[CTL_PP];
      end
      tmo_a <= tc_a | (tmo_a & ~(wr_flag & cfg_wdata[0]));
      tmo_b <= tc_b | (tmo_b & ~(wr_flag & cfg_wdata[1]));
      if (wr_route) begin
        cmb_fn  <= cmb_fn_e'(cfg_wdata[1:0]);
        pin_sel <= cfg_wdata[2 +: NPINS];
      end
      if (cfg_we && cfg_addr == ADR_RLD_A)
        reload_a <= cfg_wdata[A_W-1:0];
    end
  end

  for (genvar i = 0; i < B_BYTES; i++) begin : g_rld_b
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        reload_b_pad[8*i +: 8] <= '0;
      else if (cfg_we && cfg_addr == ADR_RLD_B0 + 3'(i))
        reload_b_pad[8*i +: 8] <= cfg_wdata;
    end
  end

  // R2: a single-pass timer stops itself at terminal count
  p_single_stop_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (tc_a && !pp_en && !cont_a && !wr_ctrl) |=> !run_a);

  // R5: terminal count always raises the flag, clear or not
  p_tmo_set_a_r5: assert property (@(posedge clk) disable iff (!rst_n)
    tc_a |=> tmo_a);
  p_tmo_set_b_r5: assert property (@(posedge clk) disable iff (!rst_n)
    tc_b |=> tmo_b);

  // R6: hand-off from A to B
  p_handoff_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (tc_a && pp_en && !tc_b && !wr_ctrl) |=> (run_b && !run_a));

  // R7: simultaneous start under alternation favours A
  p_both_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctrl && cfg_wdata[CTL_PP] && cfg_wdata[CTL_RUN_A] && cfg_wdata[CTL_RUN_B])
      |=> (run_a && !run_b));

  // R8: without alternation, A's end does not wake B
  p_no_handoff_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (tc_a && !pp_en && !run_b && !tc_b && !wr_ctrl) |=> !run_b);

endmodule

// File: rtl/pp_timer_outmux.sv
`timescale 1ns/1ps
module pp_timer_outmux
  import pp_timer_pkg::*;
#(
  parameter int NPINS = 3
) (
  input  logic             tout_a,
  input  logic             tout_b,
  input  cmb_fn_e          cmb_fn,
  input  logic [NPINS-1:0] pin_sel,
  input  logic [NPINS-1:0] port_d,
  output logic [NPINS-1:0] pin_q
);

  logic mixed;
  assign mixed = combine(cmb_fn, tout_a, tout_b);

  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    logic src;
    if (i == 1) begin : g_a
      assign src = tout_a;
    end else if (i == 2) begin : g_b
      assign src = tout_b;
    end else begin : g_mix
      assign src = mixed;
    end
    assign pin_q[i] = pin_sel[i] ? src : port_d[i];
  end

endmodule

// File: rtl/pp_timer_top.sv
`timescale 1ns/1ps
module pp_timer_top
  import pp_timer_pkg::*;
#(
  parameter int A_W   = 8,
  parameter int B_W   = 16,
  parameter int NPINS = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             cfg_we,
  input  logic [2:0]       cfg_addr,
  input  logic [7:0]       cfg_wdata,
  input  logic [NPINS-1:0] port_d,
  output logic [NPINS-1:0] pin_q,
  output logic             run_a,
  output logic             run_b,
  output logic             tmo_a,
  output logic             tmo_b,
  output logic             tout_a,
  output logic             tout_b
);

  logic             tc_a, tc_b;
  cmb_fn_e          cmb_fn;
  logic [NPINS-1:0] pin_sel;
  logic [A_W-1:0]   reload_a;
  logic [B_W-1:0]   reload_b;

  pp_timer_regs #(.A_W(A_W), .B_W(B_W), .NPINS(NPINS)) regs_i (
    .clk(clk), .rst_n(rst_n),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .tc_a(tc_a), .tc_b(tc_b),
    .run_a(run_a), .run_b(run_b), .tmo_a(tmo_a), .tmo_b(tmo_b),
    .cmb_fn(cmb_fn), .pin_sel(pin_sel),
    .reload_a(reload_a), .reload_b(reload_b)
  );

  pp_timer_cnt #(.W(A_W)) cnt_a_i (
    .clk(clk), .rst_n(rst_n), .run(run_a), .tick(tick),
    .reload(reload_a), .tc(tc_a), .tout(tout_a)
  );

  pp_timer_cnt #(.W(B_W)) cnt_b_i (
    .clk(clk), .rst_n(rst_n), .run(run_b), .tick(tick),
    .reload(reload_b), .tc(tc_b), .tout(tout_b)
  );

  pp_timer_outmux #(.NPINS(NPINS)) mux_i (
    .tout_a(tout_a), .tout_b(tout_b), .cmb_fn(cmb_fn),
    .pin_sel(pin_sel), .port_d(port_d), .pin_q(pin_q)
  );

  // R6: under alternation the token is held by at most one timer
  p_one_token_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(run_a && !run_b) && !$past(cfg_we)) |-> !(run_a && run_b));

endmodule

// File: tb/pp_timer_top_tb.sv
`timescale 1ns/1ps
module pp_timer_top_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b1;
  logic       cfg_we = 1'b0;
  logic [2:0] cfg_addr = '0;
  logic [7:0] cfg_wdata = '0;
  logic [2:0] port_d = 3'b101;
  logic [2:0] pin_q;
  logic run_a, run_b, tmo_a, tmo_b, tout_a, tout_b;

  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  pp_timer_top dut_i (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .port_d(port_d), .pin_q(pin_q),
    .run_a(run_a), .run_b(run_b), .tmo_a(tmo_a), .tmo_b(tmo_b),
    .tout_a(tout_a), .tout_b(tout_b)
  );

  // single-pass table: reload value and expected run-enable length in cycles
  localparam int NVEC = 5;
  localparam int VEC_RL  [NVEC] = '{1, 5, 0, 200, 37};
  localparam int VEC_LEN [NVEC] = '{2, 6, 2, 201, 38};

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic len_a(output int n);
    n = 0;
    while (run_a && n < 5000) begin @(negedge clk); n++; end
  endtask

  task automatic len_b(output int n);
    n = 0;
    while (run_b && n < 5000) begin @(negedge clk); n++; end
  endtask

  // independent truth tables indexed by {a,b}
  function automatic logic ref_mix(input int f, input logic a, input logic b);
    logic [3:0] tt;
    case (f)
      0: tt = 4'b1000;
      1: tt = 4'b1110;
      2: tt = 4'b0001;
      default: tt = 4'b0111;
    endcase
    return tt[{a, b}];
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int n, prev, gap;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 run_a", run_a, 0);
    chk("R1 run_b", run_b, 0);
    chk("R1 tmo", {tmo_b, tmo_a}, 0);
    chk("R1 touts", {tout_b, tout_a}, 0);
    chk("R1 pins", pin_q, 3'b101);

    // R2/R9/R5 table walk, timer A single-pass
    for (int i = 0; i < NVEC; i++) begin
      wr(3'd3, 8'(VEC_RL[i]));
      prev = tout_a;
      wr(3'd0, 8'h01);
      len_a(n);
      chk("R2 single-pass length", n, VEC_LEN[i]);
      chk("R5 flag set", tmo_a, 1);
      chk("R9 toggle at tc", tout_a, 1 - prev);
      wr(3'd1, 8'h01);
      chk("R5 flag cleared", tmo_a, 0);
    end

    // R3 continuous A, reload 3
    wr(3'd3, 8'd3);
    wr(3'd0, 8'h05);
    prev = tout_a; n = 0;
    while (tout_a == prev && n < 100) begin @(negedge clk); n++; end
    prev = tout_a; gap = 0;
    while (tout_a == prev && gap < 100) begin @(negedge clk); gap++; end
    chk("R3 continuous period", gap, 3);
    chk("R3 still running", run_a, 1);
    wr(3'd0, 8'h00);
    prev = tout_a;
    repeat (10) @(negedge clk);
    chk("R9 hold while stopped", tout_a, prev);
    wr(3'd1, 8'h03);

    // R4 tick low freezes
    tick = 1'b0;
    wr(3'd3, 8'd2);
    wr(3'd0, 8'h01);
    repeat (10) @(negedge clk);
    chk("R4 run held", run_a, 1);
    chk("R4 no timeout", tmo_a, 0);
    tick = 1'b1;
    len_a(n);
    chk("R4 resumes for two ticks", n, 2);

    // R5 clear collides with terminal count
    wr(3'd1, 8'h01);
    wr(3'd3, 8'd1);
    wr(3'd0, 8'h01);
    wr(3'd1, 8'h01);
    chk("R5 set beats clear", tmo_a, 1);
    wr(3'd1, 8'h01);
    chk("R5 clear alone", tmo_a, 0);

    // R6 alternation A=3, B=5
    wr(3'd4, 8'd5);
    wr(3'd5, 8'd0);
    wr(3'd3, 8'd3);
    wr(3'd1, 8'h03);
    wr(3'd0, 8'h11);
    len_a(n);
    chk("R6 A length", n, 4);
    chk("R6 B took token", run_b, 1);
    len_b(n);
    chk("R6 B length", n, 6);
    chk("R6 A took token", run_a, 1);
    chk("R6 both flags", {tmo_b, tmo_a}, 3);
    len_a(n);
    chk("R6 A length again", n, 4);
    chk("R6 B again", run_b, 1);
    len_b(n);
    chk("R6 never both", run_a & run_b, 0);

    // R8 turn alternation off mid-pass of A
    wr(3'd0, 8'h01);
    len_a(n);
    gap = 0;
    repeat (12) begin @(negedge clk); gap += run_b; end
    chk("R8 no hand-off", gap, 0);
    chk("R8 A finished", run_a, 0);

    // R7 both set with alternation
    wr(3'd0, 8'h13);
    chk("R7 A runs", run_a, 1);
    chk("R7 B ignored", run_b, 0);
    wr(3'd0, 8'h00);

    // R10/R11 combiner and routing
    wr(3'd3, 8'd1);
    wr(3'd4, 8'd1);
    for (int f = 0; f < 4; f++) begin
      wr(3'd2, 8'((3'b111 << 2) | f));
      for (int s = 0; s < 4; s++) begin
        chk("R10 combine", pin_q[0], ref_mix(f, tout_a, tout_b));
        chk("R11 pin1 A", pin_q[1], tout_a);
        chk("R11 pin2 B", pin_q[2], tout_b);
        if (s % 2 == 0) begin wr(3'd0, 8'h01); len_a(n); end
        else begin wr(3'd0, 8'h02); len_b(n); end
      end
    end
    port_d = 3'b101;
    wr(3'd2, 8'(3'b010 << 2));
    chk("R11 mixed routing", pin_q, {1'b1, tout_a, 1'b1});
    wr(3'd2, 8'h00);
    port_d = 3'b011;
    #1;
    chk("R11 passthrough 011", pin_q, 3'b011);
    port_d = 3'b100;
    #1;
    chk("R11 passthrough 100", pin_q, 3'b100);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule